// File: doc/BRIEF.md
# Sample-Phase Tuning Sweep Controller

This block searches for a receive sample phase that a storage-card host interface can use. After a start pulse it walks a 5-bit phase setting upward from 0. For each setting it rewrites the phase field of a shared control word, and it leaves the other bits of that word as they are. It then waits a programmable settle time and pulses an interrupt-status clear carrying a 17-bit all-ones mask. Next it asks an outside agent to run one tuning transfer and takes the pass/fail answer that comes back with the acknowledge.

The lowest passing phase opens a window. The first failure after that closes it, and the window then ends one phase below the failure. If the sweep passes through phase 31 without such a failure, the window ends at 31. The block programs the rounded-down centre of the window, settles, clears the interrupt status once more and pulses done. If no phase passed, it programs phase 0 and raises the error flag instead. The result stays on the outputs until the next accepted start.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: After reset the block is idle. done_o, err_o, tune_req_o, ctl_we_o and int_clr_o are all 0, and phase_o is 0.
- R2: On every cycle with ctl_we_o high, ctl_wdata_o[20:16] equals phase_o, and every other bit of ctl_wdata_o equals the same bit of ctl_rdata_i.
- R3: Between a control write and the interrupt clear that follows it there are exactly SETTLE_CYC idle cycles. The clear is a one-cycle int_clr_o pulse with int_clr_data_o = 0x1FFFF. Each rise of tune_req_o comes in the cycle right after such a pulse.
- R4: Tuning attempts use phases 0, 1, 2, … in ascending order, with one attempt and one control write per phase.
- R5: A failing result before any pass has no effect on the outcome, and the sweep moves on to the next phase.
- R6: The first fail after a pass, at phase p, ends the sweep with no further attempts, and the window end becomes p-1.
- R7: If no fail follows the first pass up to phase 31, all 32 phases are attempted and the window end is 31.
- R8: On success the final phase is floor((rise+end)/2) and err_o is 0.
- R9: If none of the 32 phases passes, the final phase is 0 and err_o is 1.
- R10: The final phase gets its own control write, settle interval and interrupt clear, with no tuning request, and then done_o pulses.
- R11: done_o is high for exactly one cycle per sweep. phase_o and err_o hold until the next accepted start.
- R12: A start_i pulse during a running sweep is ignored, and the outcome is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (accepted only when idle) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing phase was found |
| phase_o | output | 5 | Current or final sample phase |
| ctl_rdata_i | input | 32 | Present value of the control word |
| ctl_wdata_o | output | 32 | Control word with the phase field merged in |
| ctl_we_o | output | 1 | Control word write strobe |
| int_clr_o | output | 1 | Interrupt status clear strobe |
| int_clr_data_o | output | 17 | Clear mask, all ones while int_clr_o is high |
| tune_req_o | output | 1 | Request one tuning transfer, held until acknowledged |
| tune_ack_i | input | 1 | Tuning transfer finished |
| tune_pass_i | input | 1 | Result of that transfer, valid with tune_ack_i |

## Verification
A wrong window record shows up only at the end of the sweep, as a wrong final phase_o. The number and order of attempts, however, show a wrong stop decision early: one extra or one missing tuning request at the phase where the window closes. A miscounted settle timer is visible right after the first control write, as a wrong gap before int_clr_o. A bad field merge corrupts ctl_wdata_o on the very first write. Each pass pattern is therefore chosen so that a mistake between the rise, the end and the midpoint changes either the attempt count or the final phase.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  localparam int PH_W   = 5;
  localparam int NPH    = 32;
  localparam int PH_LSB = 16;
  localparam int CTL_W  = 32;
  localparam int CLR_W  = 17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_SETTLE, ST_CLEAR, ST_PROBE, ST_CENTER, ST_DONE
  } sweep_st_e;

  // rounded-down centre of [lo, hi]
  function automatic logic [PH_W-1:0] mid_phase(input logic [PH_W-1:0] lo,
                                                input logic [PH_W-1:0] hi);
    logic [PH_W:0] s;
    s = {1'b0, lo} + {1'b0, hi};
    return s[PH_W:1];
  endfunction

  // replace the phase field, keep every other bit
  function automatic logic [CTL_W-1:0] merge_phase(input logic [CTL_W-1:0] cur,
                                                   input logic [PH_W-1:0]  ph);
    logic [CTL_W-1:0] m;
    logic [CTL_W-1:0] v;
    m = '0;
    m[PH_LSB +: PH_W] = '1;
    v = '0;
    v[PH_LSB +: PH_W] = ph;
    return (cur & ~m) | v;
  endfunction
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= CW'(CYC - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R3: a reload always restarts a non-empty wait
  generate
    if (CYC > 1) begin : g_chk
      a_r3_reload_waits: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o);
    end
  endgenerate
endmodule

// File: rtl/window_tracker.sv
module window_tracker
  import phase_tune_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            sample_i,
  input  logic            pass_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            found_o,
  output logic [PH_W-1:0] rise_o,
  output logic [PH_W-1:0] fall_o,
  output logic            stop_o
);
  logic            found_q;
  logic [PH_W-1:0] rise_q, fall_q;
  logic            last_ph;
  logic            closes;

  assign last_ph = (phase_i == PH_W'(NPH - 1));
  assign closes  = found_q && !pass_i;
  assign stop_o  = sample_i && (closes || last_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (clear_i) begin
      found_q <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (sample_i) begin
      if (pass_i && !found_q) begin
        found_q <= 1'b1;
        rise_q  <= phase_i;
      end
      if (stop_o) fall_q <= closes ? phase_i - PH_W'(1) : phase_i;
    end
  end

  assign found_o = found_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  // R5: once opened, the window start never moves within a sweep
  a_r5_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    found_q && !clear_i |=> found_q && $stable(rise_q));
  // R6: the closed window is never inverted
  a_r6_fall_not_below_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_o) && found_q |-> fall_q >= rise_q);
endmodule

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
  import phase_tune_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             done_o,
  output logic             err_o,
  output logic [PH_W-1:0]  phase_o,
  input  logic [CTL_W-1:0] ctl_rdata_i,
  output logic [CTL_W-1:0] ctl_wdata_o,
  output logic             ctl_we_o,
  output logic             int_clr_o,
  output logic [CLR_W-1:0] int_clr_data_o,
  output logic             tune_req_o,
  input  logic             tune_ack_i,
  input  logic             tune_pass_i
);
  sweep_st_e       st_q;
  logic [PH_W-1:0] phase_q;
  logic            final_q, err_q;

  // named internal events
  logic            start_acc, write_evt, clear_evt, probe_hit, settle_done;
  logic            sweep_stop, win_found;
  logic [PH_W-1:0] win_rise, win_fall;

  assign start_acc = (st_q == ST_IDLE) && start_i;
  assign write_evt = (st_q == ST_WRITE);
  assign clear_evt = (st_q == ST_CLEAR);
  assign probe_hit = (st_q == ST_PROBE) && tune_ack_i;

  settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(write_evt),
    .run_i(st_q == ST_SETTLE), .expired_o(settle_done)
  );

  window_tracker u_win (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .sample_i(probe_hit),
    .pass_i(tune_pass_i), .phase_i(phase_q), .found_o(win_found),
    .rise_o(win_rise), .fall_o(win_fall), .stop_o(sweep_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      final_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          phase_q <= '0;
          final_q <= 1'b0;
          err_q   <= 1'b0;
          st_q    <= ST_WRITE;
        end
        ST_WRITE:  st_q <= ST_SETTLE;
        ST_SETTLE: if (settle_done) st_q <= ST_CLEAR;
        ST_CLEAR:  st_q <= final_q ? ST_DONE : ST_PROBE;
        ST_PROBE: if (tune_ack_i) begin
          if (sweep_stop) st_q <= ST_CENTER;
          else begin
            phase_q <= phase_q + PH_W'(1);
            st_q    <= ST_WRITE;
          end
        end
        ST_CENTER: begin
          phase_q <= win_found ? mid_phase(win_rise, win_fall) : '0;
          err_q   <= !win_found;
          final_q <= 1'b1;
          st_q    <= ST_WRITE;
        end
        ST_DONE:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o         = (st_q == ST_DONE);
  assign err_o          = err_q;
  assign phase_o        = phase_q;
  assign ctl_we_o       = write_evt;
  assign ctl_wdata_o    = merge_phase(ctl_rdata_i, phase_q);
  assign int_clr_o      = clear_evt;
  assign int_clr_data_o = {CLR_W{clear_evt}};
  assign tune_req_o     = (st_q == ST_PROBE);

  // R11: done is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: every request is preceded by an interrupt clear
  a_r3_req_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tune_req_o) |-> $past(int_clr_o));
  // R3: the clear only follows an expired settle wait
  a_r3_clear_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |-> $past(settle_done));
  // R2: a new phase is always presented together with a control write
  a_r2_phase_moves_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_o) |-> ctl_we_o);
  // R11: results hold while idle without a start
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !start_i |=> $stable(err_o) && $stable(phase_o));
  // R9: an error always leaves phase 0 programmed
  a_r9_err_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && (st_q == ST_IDLE) |-> phase_o == '0);
  // R10: no tuning request while finishing
  a_r10_no_req_final: assert property (@(posedge clk) disable iff (!rst_n)
    final_q && (st_q != ST_IDLE) |-> !tune_req_o);
endmodule

// File: tb/phase_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_sweep_ctrl_tb_top;
  localparam int unsigned SETTLE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        done_o, err_o;
  logic [4:0]  phase_o;
  logic [31:0] ctl_rdata_i;
  logic [31:0] ctl_wdata_o;
  logic        ctl_we_o, int_clr_o, tune_req_o;
  logic [16:0] int_clr_data_o;
  logic        tune_ack_i = 1'b0;
  logic        tune_pass_i = 1'b0;

  always #2 clk = ~clk;

  phase_sweep_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
    .phase_o(phase_o), .ctl_rdata_i(ctl_rdata_i), .ctl_wdata_o(ctl_wdata_o),
    .ctl_we_o(ctl_we_o), .int_clr_o(int_clr_o), .int_clr_data_o(int_clr_data_o),
    .tune_req_o(tune_req_o), .tune_ack_i(tune_ack_i), .tune_pass_i(tune_pass_i)
  );

  int checks = 0, failures = 0;
  logic [31:0] ctl_reg = 32'hA5A5_5A5A;
  logic [31:0] pass_map = '0;
  assign ctl_rdata_i = ctl_reg;

  int cyc = 0, we_cyc = 0, n_att = 0, n_we = 0, n_clr = 0, n_done = 0, dly = 0;
  int att_ph[64];
  bit prev_req = 0, prev_clr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tuning agent: acknowledge two cycles after a request
  always @(negedge clk) begin
    if (tune_ack_i) begin
      tune_ack_i = 1'b0;
      dly = 0;
    end else if (tune_req_o) begin
      if (dly == 2) begin
        tune_ack_i  = 1'b1;
        tune_pass_i = pass_map[phase_o];
      end else dly++;
    end
  end

  // port monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ctl_we_o) begin
        chk(ctl_wdata_o[31:21] == ctl_reg[31:21] && ctl_wdata_o[15:0] == ctl_reg[15:0],
            "R2 other bits kept", int'(ctl_wdata_o[15:0]), int'(ctl_reg[15:0]));
        chk(ctl_wdata_o[20:16] == phase_o, "R2 phase field",
            int'(ctl_wdata_o[20:16]), int'(phase_o));
        ctl_reg = ctl_wdata_o;
        we_cyc = cyc;
        n_we++;
      end
      if (int_clr_o) begin
        chk(cyc - we_cyc == int'(SETTLE) + 1, "R3 settle gap", cyc - we_cyc, int'(SETTLE) + 1);
        chk(int_clr_data_o == 17'h1FFFF, "R3 clear mask", int'(int_clr_data_o), 'h1FFFF);
        n_clr++;
      end
      if (tune_req_o && !prev_req) begin
        chk(prev_clr, "R3 request follows clear", int'(prev_clr), 1);
        if (n_att < 64) att_ph[n_att] = int'(phase_o);
        n_att++;
      end
      if (done_o) n_done++;
    end
    prev_req = tune_req_o;
    prev_clr = int_clr_o;
  end

  task automatic run_case(input string name, input logic [31:0] map, input bit poke);
    int rise, fall, exp_att, exp_ph, waited;
    bit exp_err;
    logic [4:0] held_ph;
    logic held_err;
    // expected outcome from the requirements
    rise = -1;
    for (int i = 31; i >= 0; i--) if (map[i]) rise = i;
    if (rise < 0) begin
      exp_err = 1; exp_ph = 0; exp_att = 32;
    end else begin
      fall = 31; exp_att = 32;
      for (int i = 31; i > rise; i--) if (!map[i]) begin fall = i - 1; exp_att = i + 1; end
      exp_err = 0; exp_ph = (rise + fall) / 2;
    end
    pass_map = map;
    n_att = 0; n_we = 0; n_clr = 0; n_done = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    waited = 0;
    while (n_done == 0 && waited < 8000) begin
      @(negedge clk);
      start_i = (poke && (waited == 40 || waited == 41));
      waited++;
    end
    start_i = 1'b0;
    if (n_done == 0) begin
      chk(0, {"watchdog ", name}, waited, 0);
      return;
    end
    held_ph = phase_o; held_err = err_o;
    repeat (20) @(negedge clk);
    $display("case %s: attempts=%0d phase=%0d err=%0d", name, n_att, phase_o, err_o);
    chk(n_done == 1, "R11 single done pulse", n_done, 1);
    chk(phase_o == held_ph && err_o == held_err, "R11 result held", int'(phase_o), int'(held_ph));
    chk(n_att == exp_att, "R6/R7 attempt count", n_att, exp_att);
    for (int i = 0; i < n_att && i < 64; i++)
      chk(att_ph[i] == i, "R4 ascending phases", att_ph[i], i);
    chk(n_we == n_att + 1 && n_clr == n_att + 1, "R10 final write and clear", n_we, n_att + 1);
    chk(int'(ctl_reg[20:16]) == exp_ph, "R10 final phase written", int'(ctl_reg[20:16]), exp_ph);
    if (exp_err) begin
      chk(err_o == 1'b1, "R9 error flag", int'(err_o), 1);
      chk(phase_o == 5'd0, "R9 fallback phase", int'(phase_o), 0);
    end else begin
      chk(err_o == 1'b0, "R8 no error", int'(err_o), 0);
      chk(int'(phase_o) == exp_ph, "R8 centre phase", int'(phase_o), exp_ph);
    end
  endtask

  task automatic t_reset;
    chk(!done_o && !err_o && !tune_req_o && !ctl_we_o && !int_clr_o && phase_o == 0,
        "R1 reset state", int'(phase_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("mid_window", 32'h0000_1FE0, 1'b0);            // R8: rise 5, end 12 -> 8
    run_case("pre_fail_ignored", 32'h0000_FC18, 1'b0);      // R5 R6: rise 3, end 4 -> 3
    run_case("run_to_top", 32'hFFF0_0000, 1'b0);            // R7: 20..31 -> 25
    run_case("no_pass", 32'h0000_0000, 1'b0);               // R9
    run_case("only_top", 32'h8000_0000, 1'b0);              // R7: 31 -> 31
    run_case("only_zero", 32'h0000_0001, 1'b0);             // R6: 0 -> 0, no error
    run_case("all_pass", 32'hFFFF_FFFF, 1'b0);              // R7: 0..31 -> 15
    run_case("busy_start", 32'h0000_1FE0, 1'b1);            // R12: same as mid_window
    chk(n_att == 14, "R12 start while busy ignored", n_att, 14);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule